// File: doc/BRIEF.md
# Multi-dimensional DMA Command Frontend

This block sits between a core-side 32-bit register bus and the queues of a multi-dimensional DMA engine. Software first stages a transfer by writing seven registers: source address, destination address, inner length in bytes, configuration word, source stride, destination stride and repetition count. It then reads one of two launch registers, one per stream. That read has a side effect. It packs the staged values into a descriptor, tags the descriptor with the stream's next transfer identifier, pushes it into that stream's queue, and returns the identifier as the read data. The engine drains each queue through a valid/ready handshake.

The configuration word selects the source and destination protocols (external memory bus, local cluster memory, or a zero-fill/discard pseudo-protocol) and whether the multi-dimensional repetition applies. A transfer that would move data between two external-bus endpoints is refused at launch. When the engine finishes a transfer it reports the identifier, and software polls a per-stream completion register to see the last finished ID. Driver convention sends transfers whose destination is the external bus to stream 0 and all others to stream 1. The frontend launches on whichever stream's register was read.

Top module: `dma_fe_top`

## Requirements
- R1: After reset every staged register and both completion registers read 0, both streams' next identifier is 1, no descriptor is valid and no response is pending.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both high. Exactly one response follows in the next cycle. Staged registers sit at word addresses 0 source, 1 destination, 2 length, 3 config, 4 source stride, 5 destination stride, 6 repetitions, and they read back what was written.
- R3: A read of word 8 (stream 0) or word 9 (stream 1) returns that stream's current identifier with rsp_err_o low. It also pushes a descriptor packed MSB first as {id, src, dst, len, src_stride, dst_stride, reps, src_proto, dst_proto, mode3d} into that stream's queue. The staged registers keep their values.
- R4: Identifiers count per stream, each independently, advancing by one on every successful launch and wrapping from the all-ones value to 1, never 0.
- R5: Config bits [6:4] hold the source protocol and bits [9:7] the destination protocol, with external bus = 0, local memory = 1 and fill/discard = 2. A launch read with both fields 0 returns rsp_err_o high with data 0, pushes nothing and leaves the identifier unchanged.
- R6: Config bit 11 enables the multi-dimensional mode. When it is clear, the descriptor's reps field is 1 whatever was staged. When it is set, the field carries the staged count.
- R7: When the target queue (depth QDEPTH) is full, a legal launch read is held with req_ready_o low until the engine takes an entry. The held read is then accepted, and no descriptor is lost.
- R8: Each queue delivers descriptors in launch order. A descriptor presented with desc_valid_o high holds its data unchanged until desc_ready_i takes it.
- R9: A pulse on done_valid_i[s] with done_id_i slice s loads stream s's completion register. Reads of word 10 (stream 0) and word 11 (stream 1) return it zero-extended.
- R10: A write to words 8 to 15, or any access to word 7 or 12 to 15, gets rsp_err_o high with data 0 and changes no state. This means no launch and no change to the completion registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the request accepted one cycle earlier |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Refused or unmapped access |
| desc_valid_o | output | 2 | Per-stream descriptor available |
| desc_ready_i | input | 2 | Per-stream engine takes the descriptor |
| desc_data_o | output | 2*(ID_W+199) | Descriptors, stream 0 in the low slice |
| done_valid_i | input | 2 | Per-stream completion pulse |
| done_id_i | input | 2*ID_W | Completed identifiers, stream 0 in the low slice |

## Verification
Some rules are checked by the assertions on every cycle. A queue is never pushed while full. A presented descriptor stays frozen while it waits. Every accepted request yields exactly one response one cycle later. Error responses carry zero data. Identifiers never become 0 and do not move without a launch, including across a refused transfer between two external-bus endpoints. Other behaviour can only be shown by the bench's scenarios: the content of each packed descriptor, the returned identifier sequence and its wrap to 1, the reps override when the multi-dimensional bit is clear, the stall and release of a launch against a full queue, and the isolation of completion registers from stray writes.

// File: rtl/dma_fe_pkg.sv
package dma_fe_pkg;

  localparam int REG_W  = 32;
  localparam int AIDX_W = 4;
  localparam int NSTR   = 2;
  localparam int NSTAGE = 7;

  // word addresses
  localparam logic [AIDX_W-1:0] A_SRC   = 4'd0;
  localparam logic [AIDX_W-1:0] A_DST   = 4'd1;
  localparam logic [AIDX_W-1:0] A_LEN   = 4'd2;
  localparam logic [AIDX_W-1:0] A_CFG   = 4'd3;
  localparam logic [AIDX_W-1:0] A_SSTR  = 4'd4;
  localparam logic [AIDX_W-1:0] A_DSTR  = 4'd5;
  localparam logic [AIDX_W-1:0] A_REPS  = 4'd6;
  localparam logic [AIDX_W-1:0] A_NEXT0 = 4'd8;
  localparam logic [AIDX_W-1:0] A_NEXT1 = 4'd9;
  localparam logic [AIDX_W-1:0] A_DONE0 = 4'd10;
  localparam logic [AIDX_W-1:0] A_DONE1 = 4'd11;

  // configuration word layout
  localparam int CFG_SRCP_LSB = 4;
  localparam int CFG_DSTP_LSB = 7;
  localparam int CFG_MD_BIT   = 11;

  typedef enum logic [2:0] {
    PROTO_EXT  = 3'd0,
    PROTO_LOC  = 3'd1,
    PROTO_FILL = 3'd2
  } proto_e;

  typedef struct packed {
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] len;
    logic [REG_W-1:0] src_stride;
    logic [REG_W-1:0] dst_stride;
    logic [REG_W-1:0] reps;
    logic [2:0]       src_proto;
    logic [2:0]       dst_proto;
    logic             mode3d;
  } xfer_t;

  localparam int XFER_W = $bits(xfer_t);

  function automatic logic [2:0] cfg_src_proto(logic [REG_W-1:0] cfg);
    return cfg[CFG_SRCP_LSB +: 3];
  endfunction

  function automatic logic [2:0] cfg_dst_proto(logic [REG_W-1:0] cfg);
    return cfg[CFG_DSTP_LSB +: 3];
  endfunction

  // external-bus to external-bus moves are refused
  function automatic logic cfg_illegal(logic [REG_W-1:0] cfg);
    return (cfg_src_proto(cfg) == PROTO_EXT) && (cfg_dst_proto(cfg) == PROTO_EXT);
  endfunction

  function automatic xfer_t build_xfer(logic [NSTAGE-1:0][REG_W-1:0] r);
    xfer_t x;
    x.src        = r[A_SRC[2:0]];
    x.dst        = r[A_DST[2:0]];
    x.len        = r[A_LEN[2:0]];
    x.src_stride = r[A_SSTR[2:0]];
    x.dst_stride = r[A_DSTR[2:0]];
    x.mode3d     = r[A_CFG[2:0]][CFG_MD_BIT];
    x.reps       = x.mode3d ? r[A_REPS[2:0]] : REG_W'(1);
    x.src_proto  = cfg_src_proto(r[A_CFG[2:0]]);
    x.dst_proto  = cfg_dst_proto(r[A_CFG[2:0]]);
    return x;
  endfunction

endpackage

// File: rtl/dma_fe_stage.sv
module dma_fe_stage
  import dma_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AIDX_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              hit_o,
  output logic [REG_W-1:0]  rdata_o,
  output xfer_t             xfer_o,
  output logic              illegal_o
);

  logic [NSTAGE-1:0][REG_W-1:0] regs_q;

  assign hit_o = (addr_i < AIDX_W'(NSTAGE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NSTAGE; i++) begin
        if (wr_i && (addr_i == AIDX_W'(i))) regs_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_o   = hit_o ? regs_q[addr_i[2:0]] : '0;
  assign xfer_o    = build_xfer(regs_q);
  assign illegal_o = cfg_illegal(regs_q[A_CFG[2:0]]);

  // R3: staged values only move on a write to them
  p_stage_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(regs_q));

endmodule

// File: rtl/dma_fe_idgen.sv
module dma_fe_idgen #(
  parameter int ID_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bump_i,
  output logic [ID_W-1:0] id_o
);

  localparam logic [ID_W-1:0] ID_MAX = '1;

  function automatic logic [ID_W-1:0] id_next(logic [ID_W-1:0] id);
    return (id == ID_MAX) ? ID_W'(1) : id + ID_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     id_o <= ID_W'(1);
    else if (bump_i) id_o <= id_next(id_o);
  end

  p_id_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_o != '0);

  p_id_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bump_i |=> $stable(id_o));

endmodule

// File: rtl/dma_fe_fifo.sv
module dma_fe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] dout_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign pop     = valid_o && ready_i;
  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign dout_o  = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= ptr_inc(wp_q);
      if (pop)    rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  p_desc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(dout_o)));

endmodule

// File: rtl/dma_fe_top.sv
module dma_fe_top
  import dma_fe_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int QDEPTH = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_valid_i,
  output logic                                req_ready_o,
  input  logic                                req_write_i,
  input  logic [3:0]                          req_addr_i,
  input  logic [31:0]                         req_wdata_i,
  output logic                                rsp_valid_o,
  output logic [31:0]                         rsp_rdata_o,
  output logic                                rsp_err_o,
  output logic [1:0]                          desc_valid_o,
  input  logic [1:0]                          desc_ready_i,
  output logic [2*(ID_W+XFER_W)-1:0]          desc_data_o,
  input  logic [1:0]                          done_valid_i,
  input  logic [2*ID_W-1:0]                   done_id_i
);

  localparam int DESC_W = ID_W + XFER_W;

  // named internal events
  logic              accept;
  logic              is_next;
  logic              next_sel;
  logic              launch_ok;
  logic              launch_bad;
  logic              stage_hit;
  logic              illegal;
  logic [REG_W-1:0]  stage_rdata;
  xfer_t             stage_xfer;
  logic              push     [NSTR];
  logic              q_full   [NSTR];
  logic [ID_W-1:0]   cur_id   [NSTR];
  logic [ID_W-1:0]   done_q   [NSTR];
  logic [REG_W-1:0]  rd_data;
  logic              rd_err;

  assign is_next    = !req_write_i && ((req_addr_i == A_NEXT0) || (req_addr_i == A_NEXT1));
  assign next_sel   = req_addr_i[0];
  assign req_ready_o = !(is_next && !illegal && q_full[next_sel]);
  assign accept     = req_valid_i && req_ready_o;
  assign launch_ok  = accept && is_next && !illegal;
  assign launch_bad = accept && is_next && illegal;

  dma_fe_stage u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (accept && req_write_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .hit_o     (stage_hit),
    .rdata_o   (stage_rdata),
    .xfer_o    (stage_xfer),
    .illegal_o (illegal)
  );

  for (genvar s = 0; s < NSTR; s++) begin : g_str
    assign push[s] = launch_ok && (next_sel == 1'(s));

    dma_fe_idgen #(.ID_W(ID_W)) u_id (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bump_i (push[s]),
      .id_o   (cur_id[s])
    );

    dma_fe_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) u_q (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[s]),
      .din_i   ({cur_id[s], stage_xfer}),
      .full_o  (q_full[s]),
      .valid_o (desc_valid_o[s]),
      .ready_i (desc_ready_i[s]),
      .dout_o  (desc_data_o[s*DESC_W +: DESC_W])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              done_q[s] <= '0;
      else if (done_valid_i[s]) done_q[s] <= done_id_i[s*ID_W +: ID_W];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_err  = 1'b0;
    if (stage_hit) begin
      rd_data = req_write_i ? '0 : stage_rdata;
    end else if (is_next) begin
      if (illegal) rd_err = 1'b1;
      else         rd_data = REG_W'(cur_id[next_sel]);
    end else if (!req_write_i && ((req_addr_i == A_DONE0) || (req_addr_i == A_DONE1))) begin
      rd_data = REG_W'(done_q[req_addr_i[0]]);
    end else begin
      rd_err = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_rdata_o <= rd_data;
        rsp_err_o   <= rd_err;
      end
    end
  end

  p_rsp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);

  p_no_spurious_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !rsp_valid_o);

  p_err_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == '0));

  p_reject_id_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_bad |=> ($stable(cur_id[0]) && $stable(cur_id[1])));

  p_one_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push[0] && push[1]));

endmodule

// File: tb/dma_fe_top_tb.sv
module dma_fe_top_tb;

  localparam int ID_W   = 8;
  localparam int QDEPTH = 4;
  localparam int DESC_W = ID_W + 199;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]        req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              req_ready, rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic [1:0]        desc_valid;
  logic [1:0]        rdy = 2'b11;
  logic [2*DESC_W-1:0] desc_data;
  logic [1:0]        done_valid = '0;
  logic [2*ID_W-1:0] done_id = '0;

  dma_fe_top #(.ID_W(ID_W), .QDEPTH(QDEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .desc_valid_o(desc_valid), .desc_ready_i(rdy), .desc_data_o(desc_data),
    .done_valid_i(done_valid), .done_id_i(done_id)
  );

  int total = 0, bad = 0;
  logic [DESC_W-1:0] exp_q0 [$];
  logic [DESC_W-1:0] exp_q1 [$];
  logic [ID_W-1:0]   sid [2];
  logic [31:0] m_src = 0, m_dst = 0, m_len = 0, m_cfg = 0, m_ss = 0, m_ds = 0, m_reps = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R2 response one cycle after accept", rsp_valid, 1);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    bus(1'b1, a, d, rd, er);
    chk(er == 1'b0, "R2 staged write accepted", er, 0);
    case (a)
      4'd0: m_src = d;  4'd1: m_dst = d; 4'd2: m_len = d; 4'd3: m_cfg = d;
      4'd4: m_ss = d;   4'd5: m_ds = d;  4'd6: m_reps = d;
      default: ;
    endcase
  endtask

  task automatic stage(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                       input logic [31:0] c, input logic [31:0] ss, input logic [31:0] ds,
                       input logic [31:0] r);
    wreg(4'd0, s); wreg(4'd1, d); wreg(4'd2, l); wreg(4'd3, c);
    wreg(4'd4, ss); wreg(4'd5, ds); wreg(4'd6, r);
  endtask

  task automatic launch(input int s, input string tag);
    logic [31:0] rd; logic er;
    logic [DESC_W-1:0] e;
    e = {sid[s], m_src, m_dst, m_len, m_ss, m_ds, (m_cfg[11] ? m_reps : 32'd1),
         m_cfg[6:4], m_cfg[9:7], m_cfg[11]};
    if (s == 0) exp_q0.push_back(e); else exp_q1.push_back(e);
    bus(1'b0, (s == 0) ? 4'd8 : 4'd9, 32'd0, rd, er);
    chk(er == 1'b0 && rd == 32'(sid[s]), tag, {er, rd}, {1'b0, 32'(sid[s])});
    sid[s] = (sid[s] == '1) ? ID_W'(1) : sid[s] + ID_W'(1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (desc_valid[0] && rdy[0]) begin
        if (exp_q0.size() == 0) chk(1'b0, "R3 unexpected descriptor on stream 0", desc_data[DESC_W-1:0], 0);
        else begin
          logic [DESC_W-1:0] e;
          e = exp_q0.pop_front();
          chk(desc_data[DESC_W-1:0] == e, "R3 R8 descriptor stream 0", desc_data[DESC_W-1:0], e);
        end
      end
      if (desc_valid[1] && rdy[1]) begin
        if (exp_q1.size() == 0) chk(1'b0, "R3 unexpected descriptor on stream 1", desc_data[2*DESC_W-1:DESC_W], 0);
        else begin
          logic [DESC_W-1:0] e;
          e = exp_q1.pop_front();
          chk(desc_data[2*DESC_W-1:DESC_W] == e, "R3 R8 descriptor stream 1", desc_data[2*DESC_W-1:DESC_W], e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic er;
    logic [DESC_W-1:0] held;
    sid[0] = ID_W'(1); sid[1] = ID_W'(1);
    repeat (4) @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(desc_valid == 2'b00, "R1 no descriptor after reset", desc_valid, 0);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    bus(1'b0, 4'd0, 0, rd, er); chk(rd == 0 && !er, "R1 source reads 0", rd, 0);
    bus(1'b0, 4'd3, 0, rd, er); chk(rd == 0, "R1 config reads 0", rd, 0);
    bus(1'b0, 4'd10, 0, rd, er); chk(rd == 0 && !er, "R1 completion 0 reads 0", rd, 0);
    bus(1'b0, 4'd11, 0, rd, er); chk(rd == 0, "R1 completion 1 reads 0", rd, 0);

    // R2 readback; R6 bit 11 set, local->local
    stage(32'h1000_0010, 32'h2000_0020, 32'd64, 32'h0000_0800 | (32'd1 << 4) | (32'd1 << 7),
          32'd128, 32'd256, 32'd5);
    bus(1'b0, 4'd1, 0, rd, er); chk(rd == 32'h2000_0020, "R2 destination readback", rd, 32'h2000_0020);
    bus(1'b0, 4'd6, 0, rd, er); chk(rd == 32'd5, "R2 repetitions readback", rd, 5);
    launch(1, "R3 R4 first stream 1 id is 1");
    launch(1, "R4 second stream 1 id is 2");
    bus(1'b0, 4'd4, 0, rd, er); chk(rd == 32'd128, "R3 staged stride kept after launch", rd, 128);

    // R6 bit 11 clear, local -> external, stream 0
    wreg(4'd3, (32'd1 << 4) | (32'd0 << 7));
    wreg(4'd6, 32'd7);
    launch(0, "R4 R6 stream 0 independent id 1, reps forced 1");
    wreg(4'd3, 32'h0000_0800 | (32'd2 << 4) | (32'd1 << 7));
    launch(1, "R6 fill source, staged reps carried");

    // R5 external -> external refused
    wreg(4'd3, 32'h0000_0800);
    bus(1'b0, 4'd8, 0, rd, er);
    chk(er == 1'b1 && rd == 0, "R5 both external refused", {er, rd}, {1'b1, 32'd0});
    bus(1'b0, 4'd9, 0, rd, er);
    chk(er == 1'b1, "R5 refused on stream 1 too", er, 1);
    repeat (3) @(negedge clk);
    chk(desc_valid == 2'b00, "R5 nothing queued", desc_valid, 0);
    wreg(4'd3, (32'd0 << 4) | (32'd1 << 7));
    launch(0, "R5 id unchanged after refusal");

    // R10
    bus(1'b1, 4'd9, 32'h55, rd, er); chk(er == 1'b1 && rd == 0, "R10 write to launch reg", {er, rd}, {1'b1, 32'd0});
    bus(1'b0, 4'd7, 0, rd, er); chk(er == 1'b1 && rd == 0, "R10 unmapped read", {er, rd}, {1'b1, 32'd0});
    bus(1'b0, 4'd14, 0, rd, er); chk(er == 1'b1, "R10 high unmapped read", er, 1);
    repeat (3) @(negedge clk);
    chk(desc_valid == 2'b00, "R10 write to launch reg does not launch", desc_valid, 0);

    // R9
    @(posedge clk); #1 done_valid = 2'b10; done_id = {ID_W'(8'h2a), ID_W'(8'h11)};
    @(posedge clk); #1 done_valid = 2'b00; done_id = '0;
    bus(1'b0, 4'd11, 0, rd, er); chk(rd == 32'h2a, "R9 completion 1 loaded", rd, 32'h2a);
    bus(1'b0, 4'd10, 0, rd, er); chk(rd == 0, "R9 completion 0 untouched", rd, 0);
    bus(1'b1, 4'd11, 32'hff, rd, er); chk(er == 1'b1, "R10 write to completion refused", er, 1);
    bus(1'b0, 4'd11, 0, rd, er); chk(rd == 32'h2a, "R10 completion kept after write", rd, 32'h2a);

    // R8 hold while not ready, then order
    @(posedge clk); #1 rdy[0] = 1'b0;
    wreg(4'd0, 32'hAAAA_0000); launch(0, "R8 first held launch");
    wreg(4'd0, 32'hBBBB_0000); launch(0, "R8 second held launch");
    @(negedge clk); held = desc_data[DESC_W-1:0];
    repeat (3) @(negedge clk);
    chk(desc_valid[0] && desc_data[DESC_W-1:0] == held, "R8 descriptor stable while waiting",
        desc_data[DESC_W-1:0], held);
    @(posedge clk); #1 rdy[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q0.size() == 0, "R8 both drained in order", exp_q0.size(), 0);

    // R7 stall on full
    wreg(4'd3, (32'd1 << 4) | (32'd1 << 7));
    @(posedge clk); #1 rdy[1] = 1'b0;
    for (int i = 0; i < QDEPTH; i++) begin
      wreg(4'd2, 32'(i + 1)); launch(1, "R7 fill queue");
    end
    wreg(4'd2, 32'd99);
    fork
      launch(1, "R7 stalled launch completes");
      begin
        repeat (6) @(negedge clk);
        chk(req_ready == 1'b0, "R7 ready low on full queue", req_ready, 0);
        @(posedge clk); #1 rdy[1] = 1'b1;
      end
    join
    repeat (QDEPTH + 4) @(negedge clk);
    chk(exp_q1.size() == 0, "R7 no descriptor lost", exp_q1.size(), 0);

    // R4 wrap on stream 0
    while (sid[0] != '1) launch(0, "R4 counting");
    launch(0, "R4 all-ones id");
    launch(0, "R4 wraps to 1");
    repeat (4) @(negedge clk);
    chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R3 scoreboard empty", exp_q0.size() + exp_q1.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule